// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block returns a stuck two-wire serial bus to the idle state. A target can lose its place in a byte and hold the data line low, which blocks every later transfer. The sequencer uses two open-drain lines. It drives each line only through an active-high pull-low enable and reads both lines back. On a start request it releases both lines and then clocks the bus nine times. During those clocks it records whether the data line was ever read high. If the data line did go high, it issues a START followed by a STOP, keeping the clock line released for the whole of both conditions. It then waits out a bus-free interval and reports completion.

All timings are parameters counted in system clock cycles. A target that holds the clock line low stretches the current high phase, because that phase does not begin until the clock line reads high. The block has three results. `done_o` is a one-cycle completion pulse. `wedged_o` reports that the data line never came free. `pins_warn_o` reports that the lines were not both high just before the START.

The FSM states are as follows:
- `ST_IDLE`: waits for a request.
- `ST_RELEASE`: both lines released for HIGH_CYC cycles.
- `ST_CLK_LOW`: clock pulled low for LOW_CYC cycles.
- `ST_CLK_RISE`: clock released, waiting until it reads high.
- `ST_CLK_HIGH`: HIGH_CYC cycles, with data sampled in the last cycle.
- `ST_START_SETUP`: SETUP_CYC cycles.
- `ST_START_HOLD`: data pulled low for HOLD_CYC cycles.
- `ST_BUS_FREE`: BUF_CYC cycles.
- `ST_FINISH`: a single cycle with done asserted.

The FSM transitions are as follows:
- IDLE to RELEASE on an accepted start.
- RELEASE to CLK_LOW when its timer expires.
- CLK_LOW to CLK_RISE when its timer expires.
- CLK_RISE to CLK_HIGH once the clock line reads high.
- CLK_HIGH to CLK_LOW when the timer expires before the last pulse.
- CLK_HIGH to START_SETUP after the last pulse, if data was seen high.
- CLK_HIGH to FINISH after the last pulse, if data was never seen high.
- START_SETUP to START_HOLD to BUS_FREE to FINISH, each when its timer expires.
- FINISH to IDLE unconditionally.

Top module: `twbus_unjam`

## Requirements
- R1: While reset is low and after it is released, both pull enables, `busy_o`, `done_o`, `wedged_o` and `pins_warn_o` are 0.
- R2: A start request sampled high in idle is accepted at that clock edge, and `busy_o` is 1 from the next cycle. Both lines then stay released for HIGH_CYC cycles before the first clock pulse.
- R3: Exactly NUM_PULSES (9) clock-low pulses are issued. Each pulse keeps `scl_pull_o` at 1 for LOW_CYC cycles. `sda_pull_o` stays 0 for as long as pulses remain to be issued.
- R4: After each low pulse the sequencer waits until `scl_i` reads 1, so a target holding SCL low for K cycles lengthens the run by K cycles. The high phase then lasts HIGH_CYC cycles, and `sda_i` is sampled in its last cycle.
- R5: All nine pulses are issued even when SDA was already seen high at an earlier pulse.
- R6: If SDA was 0 at all nine samples, no START or STOP is issued (`sda_pull_o` never 1) and `wedged_o` becomes 1. The run then ends with done directly after the ninth high phase.
- R7: Otherwise `scl_pull_o` stays 0 from the ninth pulse until done. After SETUP_CYC cycles `sda_pull_o` is 1 for exactly HOLD_CYC cycles, and is never 1 together with `scl_pull_o`.
- R8: After `sda_pull_o` returns to 0, BUF_CYC cycles pass before `done_o` is asserted.
- R9: If `scl_i` and `sda_i` are not both 1 in the last setup cycle before the START, `pins_warn_o` becomes 1 and the START and STOP still proceed.
- R10: `done_o` is exactly one cycle wide, once per accepted start. Start requests while busy are ignored and do not change the run length.
- R11: `wedged_o` and `pins_warn_o` hold their value after done and are cleared when the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Recovery request, sampled in idle |
| scl_i | input | 1 | Sampled level of the clock line |
| sda_i | input | 1 | Sampled level of the data line |
| scl_pull_o | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wedged_o | output | 1 | Data line never read high during the pulses |
| pins_warn_o | output | 1 | Lines not both high before the START |

## Verification
Each result has its own timing. `busy_o` rises one cycle after the accepting edge. The run length is HIGH + 9·(LOW+1+HIGH) + K, plus SETUP+HOLD+BUF when the bus is live, plus one cycle for done. Here K is the number of cycles the target stretched the clock.

The bench measures every interval on the falling edge, where the Moore outputs are settled. These intervals are each low-pulse width, the release time before the first pulse, the SDA hold width, and the gap from the SDA release to done. Each is compared against the figure computed from the parameters. The result flags are read once the run has returned to idle, and again a few cycles after the next start to confirm they were cleared.

// File: rtl/twbus_unjam_pkg.sv
package twbus_unjam_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RELEASE,
        ST_CLK_LOW,
        ST_CLK_RISE,
        ST_CLK_HIGH,
        ST_START_SETUP,
        ST_START_HOLD,
        ST_BUS_FREE,
        ST_FINISH
    } unjam_state_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/twu_phase_timer.sv
// Phase timer: counts cycles since the last clear; expired marks the
// final cycle of a phase that lasts len cycles.
module twu_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [W-1:0] len,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == (len - 1'b1));
endmodule

// File: rtl/twu_pulse_tally.sv
// Counts finished clock pulses and remembers whether the data line was
// read high at the end of any high phase.
module twu_pulse_tally #(
    parameter int NUM_PULSES = 9,
    localparam int CW = $clog2(NUM_PULSES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic sda_sample,
    output logic last_pulse,
    output logic seen_high
);
    logic [CW-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q   <= '0;
            seen_high <= 1'b0;
        end else if (clear) begin
            count_q   <= '0;
            seen_high <= 1'b0;
        end else if (step) begin
            count_q   <= count_q + 1'b1;
            seen_high <= seen_high | sda_sample;
        end
    end

    assign last_pulse = (count_q == CW'(NUM_PULSES - 1));
endmodule

// File: rtl/twbus_unjam.sv
module twbus_unjam
    import twbus_unjam_pkg::*;
#(
    parameter int LOW_CYC    = 40,
    parameter int HIGH_CYC   = 40,
    parameter int SETUP_CYC  = 50,
    parameter int HOLD_CYC   = 50,
    parameter int BUF_CYC    = 3000,
    parameter int NUM_PULSES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_pull_o,
    output logic sda_pull_o,
    output logic busy_o,
    output logic done_o,
    output logic wedged_o,
    output logic pins_warn_o
);
    localparam int MAX_LEN = max_of(max_of(max_of(LOW_CYC, HIGH_CYC),
                                           max_of(SETUP_CYC, HOLD_CYC)), BUF_CYC);
    localparam int TW = $clog2(MAX_LEN + 1);
    localparam logic [TW-1:0] LEN_LOW   = TW'(LOW_CYC);
    localparam logic [TW-1:0] LEN_HIGH  = TW'(HIGH_CYC);
    localparam logic [TW-1:0] LEN_SETUP = TW'(SETUP_CYC);
    localparam logic [TW-1:0] LEN_HOLD  = TW'(HOLD_CYC);
    localparam logic [TW-1:0] LEN_BUF   = TW'(BUF_CYC);

    unjam_state_t state_q, state_d;
    logic [TW-1:0] phase_len;
    logic phase_done, timer_clear;
    logic start_ok, high_end, last_pulse, seen_high, bus_live;

    assign start_ok    = (state_q == ST_IDLE) && start_i;
    assign high_end    = (state_q == ST_CLK_HIGH) && phase_done;
    assign bus_live    = seen_high || sda_i;
    assign timer_clear = (state_d != state_q) || (state_q == ST_IDLE);

    always_comb begin
        unique case (state_q)
            ST_CLK_LOW:     phase_len = LEN_LOW;
            ST_START_SETUP: phase_len = LEN_SETUP;
            ST_START_HOLD:  phase_len = LEN_HOLD;
            ST_BUS_FREE:    phase_len = LEN_BUF;
            default:        phase_len = LEN_HIGH;
        endcase
    end

    twu_phase_timer #(.W(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (timer_clear),
        .len     (phase_len),
        .expired (phase_done)
    );

    twu_pulse_tally #(.NUM_PULSES(NUM_PULSES)) u_tally (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (start_ok),
        .step       (high_end),
        .sda_sample (sda_i),
        .last_pulse (last_pulse),
        .seen_high  (seen_high)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (start_i)    state_d = ST_RELEASE;
            ST_RELEASE:     if (phase_done) state_d = ST_CLK_LOW;
            ST_CLK_LOW:     if (phase_done) state_d = ST_CLK_RISE;
            ST_CLK_RISE:    if (scl_i)      state_d = ST_CLK_HIGH;
            ST_CLK_HIGH: begin
                if (phase_done) begin
                    if (!last_pulse)   state_d = ST_CLK_LOW;
                    else if (bus_live) state_d = ST_START_SETUP;
                    else               state_d = ST_FINISH;
                end
            end
            ST_START_SETUP: if (phase_done) state_d = ST_START_HOLD;
            ST_START_HOLD:  if (phase_done) state_d = ST_BUS_FREE;
            ST_BUS_FREE:    if (phase_done) state_d = ST_FINISH;
            ST_FINISH:                      state_d = ST_IDLE;
            default:                        state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Result flags: cleared on acceptance, held after done
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wedged_o    <= 1'b0;
            pins_warn_o <= 1'b0;
        end else if (start_ok) begin
            wedged_o    <= 1'b0;
            pins_warn_o <= 1'b0;
        end else begin
            if (high_end && last_pulse && !bus_live)
                wedged_o <= 1'b1;
            if ((state_q == ST_START_SETUP) && phase_done && !(scl_i && sda_i))
                pins_warn_o <= 1'b1;
        end
    end

    // Moore outputs
    always_comb begin
        scl_pull_o = 1'b0;
        sda_pull_o = 1'b0;
        done_o     = 1'b0;
        busy_o     = (state_q != ST_IDLE);
        unique case (state_q)
            ST_CLK_LOW:    scl_pull_o = 1'b1;
            ST_START_HOLD: sda_pull_o = 1'b1;
            ST_FINISH:     done_o     = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/twbus_unjam_chk.sv
module twbus_unjam_chk #(
    parameter int NUM_PULSES = 9
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic scl_i,
    input logic scl_pull_o,
    input logic sda_pull_o,
    input logic busy_o,
    input logic done_o,
    input logic wedged_o,
    input logic pins_warn_o
);
    int   pulse_cnt;
    logic prev_scl_pull;
    logic sda_used;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_cnt     <= 0;
            prev_scl_pull <= 1'b0;
            sda_used      <= 1'b0;
        end else begin
            prev_scl_pull <= scl_pull_o;
            if (!busy_o && start_i) begin
                pulse_cnt <= 0;
                sda_used  <= 1'b0;
            end else begin
                if (scl_pull_o && !prev_scl_pull) pulse_cnt <= pulse_cnt + 1;
                if (sda_pull_o) sda_used <= 1'b1;
            end
        end
    end

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_busy_from_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull_o |-> (!scl_pull_o && scl_i));
    assert_scl_kept_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull_o |=> !scl_pull_o);
    assert_pulse_total_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pulse_cnt == NUM_PULSES));
    assert_pulse_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_cnt <= NUM_PULSES);
    assert_wedged_no_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && wedged_o) |-> !sda_used);
    assert_warn_in_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pins_warn_o) |-> (busy_o && !scl_pull_o));
endmodule

bind twbus_unjam twbus_unjam_chk #(.NUM_PULSES(NUM_PULSES)) u_unjam_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .scl_i       (scl_i),
    .scl_pull_o  (scl_pull_o),
    .sda_pull_o  (sda_pull_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .wedged_o    (wedged_o),
    .pins_warn_o (pins_warn_o)
);

// File: tb/test_twbus_unjam.sv
module test_twbus_unjam;
    localparam int LOW   = 40;
    localparam int HIGH  = 40;
    localparam int SETUP = 50;
    localparam int HOLD  = 50;
    localparam int BUFC  = 3000;
    localparam int NP    = 9;

    typedef struct packed {
        logic [8:0] mask;  // bit n-1: SDA level target drives during high phase n
        logic [3:0] sidx;  // pulse after which SCL is held low (0 = none)
        logic [7:0] slen;  // stretch length in cycles
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{9'h1FF, 4'd0, 8'd0},
        '{9'h000, 4'd0, 8'd0},
        '{9'h100, 4'd0, 8'd0},
        '{9'h001, 4'd0, 8'd0},
        '{9'h0F0, 4'd0, 8'd0},
        '{9'h1FF, 4'd3, 8'd37},
        '{9'h0AA, 4'd9, 8'd5},
        '{9'h000, 4'd1, 8'd12}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic scl_i, sda_i;
    logic scl_pull_o, sda_pull_o, busy_o, done_o, wedged_o, pins_warn_o;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    logic [8:0] cur_mask = 9'h1FF;
    int cur_sidx = 0;
    int cur_slen = 0;
    logic hold_scl = 1'b0;
    logic sda_tgt;

    int busy_cyc, done_cnt, pre_cyc, pulses, low_run, low_min, low_max;
    int rem, sda_cyc, sda_early, gap, scl_late;
    bit first_low, sda_fell, prev_scl, prev_sda;

    always #10 clk = ~clk;

    assign scl_i = ~scl_pull_o & ~hold_scl;
    assign sda_i = ~sda_pull_o & sda_tgt;
    always_comb sda_tgt = (pulses == 0) ? 1'b1 : cur_mask[((pulses > 9) ? 9 : pulses) - 1];

    twbus_unjam #(
        .LOW_CYC(LOW), .HIGH_CYC(HIGH), .SETUP_CYC(SETUP),
        .HOLD_CYC(HOLD), .BUF_CYC(BUFC), .NUM_PULSES(NP)
    ) i_twbus_unjam (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .scl_i(scl_i), .sda_i(sda_i),
        .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o), .busy_o(busy_o),
        .done_o(done_o), .wedged_o(wedged_o), .pins_warn_o(pins_warn_o)
    );

    // Monitor on the falling edge, where Moore outputs are settled
    always @(negedge clk) begin
        if (busy_o) busy_cyc++;
        if (done_o) done_cnt++;
        if (busy_o && pulses == 0 && !scl_pull_o && !first_low) pre_cyc++;
        if (scl_pull_o) begin
            first_low = 1;
            low_run++;
        end else if (prev_scl) begin
            pulses++;
            if (low_run < low_min) low_min = low_run;
            if (low_run > low_max) low_max = low_run;
            low_run = 0;
            if (pulses == cur_sidx && cur_slen > 0) rem = cur_slen;
        end else if (rem > 0) begin
            rem--;
        end
        hold_scl = (rem > 0);
        if (sda_pull_o) begin
            sda_cyc++;
            if (pulses < NP) sda_early++;
        end
        if (!sda_pull_o && prev_sda) sda_fell = 1;
        if (sda_fell && !done_o && busy_o) gap++;
        if (pulses >= NP && scl_pull_o) scl_late++;
        prev_scl = scl_pull_o;
        prev_sda = sda_pull_o;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        busy_cyc = 0; done_cnt = 0; pre_cyc = 0; pulses = 0; low_run = 0;
        low_min = 1000000; low_max = 0; rem = 0; sda_cyc = 0; sda_early = 0;
        gap = 0; scl_late = 0; first_low = 0; sda_fell = 0; prev_scl = 0;
        prev_sda = 0; hold_scl = 0;
    endtask

    task automatic run_vec(input vec_t v, input bit spam);
        bit ok_bus;
        bit exp_warn;
        int exp_busy;
        ok_bus   = (v.mask != 9'h000);
        exp_warn = ok_bus && !v.mask[8];
        exp_busy = HIGH + NP * (LOW + 1 + HIGH) + int'(v.slen) + 1
                 + (ok_bus ? (SETUP + HOLD + BUFC) : 0);
        @(posedge clk);
        cur_mask = v.mask;
        cur_sidx = int'(v.sidx);
        cur_slen = int'(v.slen);
        clear_mon();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b1, "R2 busy after accept", busy_o, 1);
        chk(!wedged_o && !pins_warn_o, "R11 flags cleared at start", {wedged_o, pins_warn_o}, 0);
        for (int w = 0; w < 20000 && done_cnt == 0; w++) begin
            @(negedge clk);
            start_i = spam && ((w % 300) == 5);
        end
        start_i = 1'b0;
        chk(done_cnt > 0, "R10 done reached", done_cnt, 1);
        repeat (4) @(negedge clk);
        chk(!busy_o, "R10 idle after done", busy_o, 0);
        chk(pulses == NP, "R3 pulse count", pulses, NP);
        chk(low_min == LOW && low_max == LOW, "R3 low width", low_max, LOW);
        chk(sda_early == 0, "R3 sda released while clocking", sda_early, 0);
        chk(pre_cyc == HIGH, "R2 release before first pulse", pre_cyc, HIGH);
        chk(busy_cyc == exp_busy, "R4 R5 run length", busy_cyc, exp_busy);
        chk(done_cnt == 1, "R10 single done pulse", done_cnt, 1);
        chk(wedged_o == !ok_bus, "R6 wedged flag", wedged_o, !ok_bus);
        chk(pins_warn_o == exp_warn, "R9 pins warning", pins_warn_o, exp_warn);
        if (ok_bus) begin
            chk(sda_cyc == HOLD, "R7 sda hold width", sda_cyc, HOLD);
            chk(scl_late == 0, "R7 scl held high after pulses", scl_late, 0);
            chk(gap == BUFC, "R8 bus free gap", gap, BUFC);
        end else begin
            chk(sda_cyc == 0, "R6 no start or stop", sda_cyc, 0);
        end
    endtask

    initial begin
        clear_mon();
        repeat (3) @(negedge clk);
        chk(!scl_pull_o && !sda_pull_o && !busy_o && !done_o && !wedged_o && !pins_warn_o,
            "R1 outputs in reset", {scl_pull_o, sda_pull_o, busy_o, done_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!scl_pull_o && !sda_pull_o && !busy_o && !done_o && !wedged_o && !pins_warn_o,
            "R1 outputs after reset", {scl_pull_o, sda_pull_o, busy_o, done_o}, 0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

        // R10: repeated start requests during a run are ignored
        run_vec('{9'h1FF, 4'd0, 8'd0}, 1'b1);
        // R11: wedged result held, then cleared by a live run
        run_vec('{9'h000, 4'd0, 8'd0}, 1'b0);
        repeat (20) @(negedge clk);
        chk(wedged_o == 1'b1, "R11 wedged held in idle", wedged_o, 1);
        run_vec('{9'h1FF, 4'd0, 8'd0}, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule